// File: doc/BRIEF.md
# Serial Port with Programmable Character Format

This block is an asynchronous serial transmitter and receiver that sits on a simple two-phase peripheral bus (select, then enable). Software writes a byte to the transmit data register and the block sends it as a serial frame on `txd`. It assembles incoming frames from `rxd` into bytes that software reads from the receive data register. Each frame is one low start bit, the data bits least significant first, an optional parity bit and one high stop bit. The line idles high. One bit period is 16 ticks, and a tick comes every `TICK_DIV` clock cycles.

A three-bit format register sets the character length (7 or 8 data bits), turns parity on or off, and picks odd or even parity. Three status outputs tell the system when a write will be accepted, when a character is waiting, and when the waiting character failed its parity check. The parameter `USE_FIFO` picks the buffering for both directions: 16-entry queues, or a one-character holding register. Two instances wired back to back carry a stream of characters without loss. If their parity settings differ, every character is flagged.

Top module: `apb_uart`

## Requirements
- R1: After reset `txd` is 1, `tx_ready` is 1, `rx_ready` is 0, `parity_err` is 0, and the format register reads 0x05.
- R2: A bus write (psel, penable and pwrite all high) to offset 0x0C loads bits [2:0] of the written byte into the format register. A read of 0x0C returns them in bits [2:0], with zeros above.
- R3: With format 0x05 (bit 0 = 1: 8 data bits; bit 1 = 0: no parity), bytes written to offset 0x00 of one instance are read, in the same order and unchanged, from offset 0x04 of a linked instance.
- R4: With format 0x04 (bit 0 = 0: 7 data bits), only bits [6:0] of a written byte are sent, and the received byte has bit 7 equal to 0.
- R5: With parity on (bit 1 = 1), the transmitter adds a parity bit. Bit 2 set selects odd parity and bit 2 clear selects even parity. Linked instances with the same setting report no parity error. Bit 2 has no effect while bit 1 is 0.
- R6: When the linked instances differ in parity sense, `parity_err` is high for every received character, the data still arrives, and `parity_err` is high only while `rx_ready` is high.
- R7: A frame on `txd` is a low start bit, the data LSB first, an optional parity bit and a high stop bit. Each bit lasts 16*TICK_DIV clocks, and `txd` changes only on tick boundaries.
- R8: A low pulse on `rxd` that has ended by mid start bit is ignored and produces no character. `rx_ready` rises only when a frame completes.
- R9: A read of offset 0x04 removes the oldest received character. `rx_ready` and `parity_err` then describe the next stored character, which can have a different parity status.
- R10: A write to offset 0x00 while `tx_ready` is 0 is discarded. In holding-register mode, one character can wait while another is on the line.
- R11: With `USE_FIFO`=1, up to 16 characters can wait behind the one being sent. `tx_ready` drops when the queue is full, and characters written after that are not sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset: 0x00 transmit, 0x04 receive, 0x0C format |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data (combinational from paddr) |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output, idles high |
| tx_ready | output | 1 | A transmit write will be accepted |
| rx_ready | output | 1 | A received character is waiting |
| parity_err | output | 1 | The waiting character failed its parity check |

## Verification
Two instances are linked: a queued one as sender and a holding-register one as receiver. Character streams are sent through them under every format: 8 bits without parity, 7 bits with bit 7 set in the written data, even and odd parity on both sides, parity off with bit 2 set on one side only, and both parity mismatches. These runs separate data-path errors, truncation to 7 bits, errors in parity generation or checking, and a flag that appears or is missed per character. A frame is also sampled bit by bit at mid-bit to pin down bit order, the parity bit and bit length. Back-to-back writes show the full point of the queue and of the holding register. A short pulse on the line must be rejected. Characters that differ in parity status are read out of the queue in turn to confirm that both flags follow each pop.

// File: rtl/uart_cfg_pkg.sv
package uart_cfg_pkg;

   // packed so that bit 2 = odd, bit 1 = parity on, bit 0 = 8-bit length
   typedef struct packed {
      logic odd;
      logic par_en;
      logic len8;
   } frame_fmt_t;

   localparam logic [2:0] FMT_RESET = 3'b101;
   localparam int OFS_TXD   = 0;
   localparam int OFS_RXD   = 4;
   localparam int OFS_CTRL  = 12;
   localparam int FRAME_MAX = 11;

   // parity bit that makes the data ones plus parity even (or odd when f.odd)
   function automatic logic par_bit(input logic [7:0] d, input frame_fmt_t f);
      logic [7:0] m;
      m = f.len8 ? d : {1'b0, d[6:0]};
      return (^m) ^ f.odd;
   endfunction

endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
   parameter int TICK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

   if (TICK_DIV < 2) begin : g_bad_div
      $error("uart_tick_gen: TICK_DIV must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   assign tick = (cnt == LAST);
endmodule

// File: rtl/uart_buf.sv
module uart_buf #(
   parameter int W        = 8,
   parameter bit USE_FIFO = 1'b1,
   parameter int DEPTH    = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   logic do_push, do_pop;
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   if (USE_FIFO) begin : g_fifo
      localparam int AW = $clog2(DEPTH);
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("uart_buf: DEPTH must be a power of two of at least 2");
      end

      logic [W-1:0]  mem [DEPTH];
      logic [AW-1:0] wp, rp;
      logic [AW:0]   cnt;

      always_ff @(posedge clk) begin
         if (do_push) mem[wp] <= din;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
         end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            case ({do_push, do_pop})
               2'b10:   cnt <= cnt + 1'b1;
               2'b01:   cnt <= cnt - 1'b1;
               default: cnt <= cnt;
            endcase
         end
      end

      assign dout  = mem[rp];
      assign empty = (cnt == '0);
      assign full  = (cnt == (AW+1)'(DEPTH));
   end else begin : g_hold
      logic [W-1:0] q;
      logic         v;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
            v <= 1'b0;
         end else if (do_push) begin
            q <= din;
            v <= 1'b1;
         end else if (do_pop) begin
            v <= 1'b0;
         end
      end

      assign dout  = q;
      assign empty = !v;
      assign full  = v;
   end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
   import uart_cfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  frame_fmt_t fmt,
   input  logic       have_data,
   input  logic [7:0] data,
   output logic       take,
   output logic       txd
);
   logic                 busy;
   logic [FRAME_MAX-1:0] shreg;
   logic [3:0]           left;
   logic [3:0]           tcnt;

   logic [FRAME_MAX-1:0] frame_n;
   logic [3:0]           len_n;
   logic [3:0]           pos;

   // assemble start, data, optional parity and stop, LSB first
   always_comb begin
      frame_n    = '1;
      frame_n[0] = 1'b0;
      pos        = 4'd1;
      for (int i = 0; i < 8; i++) begin
         if (i < 7 || fmt.len8) begin
            frame_n[pos] = data[i];
            pos          = pos + 4'd1;
         end
      end
      if (fmt.par_en) begin
         frame_n[pos] = par_bit(data, fmt);
         pos          = pos + 4'd1;
      end
      frame_n[pos] = 1'b1;
      len_n        = pos + 4'd1;
   end

   assign take = !busy && tick && have_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         shreg <= '1;
         left  <= '0;
         tcnt  <= '0;
      end else if (take) begin
         busy  <= 1'b1;
         shreg <= frame_n;
         left  <= len_n;
         tcnt  <= '0;
      end else if (busy && tick) begin
         if (tcnt == 4'd15) begin
            tcnt  <= '0;
            shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
            left  <= left - 4'd1;
            if (left == 4'd1) busy <= 1'b0;
         end else begin
            tcnt <= tcnt + 4'd1;
         end
      end
   end

   assign txd = busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/uart_rx.sv
module uart_rx
   import uart_cfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  frame_fmt_t fmt,
   input  logic       rxd,
   output logic       push,
   output logic [8:0] word
);
   typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rx_state_t;

   rx_state_t  st;
   logic [1:0] sync;
   logic       rx_s;
   logic [3:0] tcnt;
   logic [2:0] idx;
   logic [7:0] data;
   logic       pbit;
   logic [2:0] last_idx;
   logic       bad_par;

   assign rx_s     = sync[1];
   assign last_idx = fmt.len8 ? 3'd7 : 3'd6;
   assign bad_par  = fmt.par_en && (par_bit(data, fmt) != pbit);
   assign push     = (st == S_STOP) && tick && (tcnt == 4'd15);
   assign word     = {bad_par, data};

   always_ff @(posedge clk) begin
      if (!rst_n) sync <= 2'b11;
      else        sync <= {sync[0], rxd};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= S_IDLE;
         tcnt <= '0;
         idx  <= '0;
         data <= '0;
         pbit <= 1'b0;
      end else if (tick) begin
         case (st)
            S_IDLE: begin
               if (!rx_s) begin
                  st   <= S_START;
                  tcnt <= '0;
               end
            end
            S_START: begin
               if (tcnt == 4'd7) begin
                  tcnt <= '0;
                  idx  <= '0;
                  data <= '0;
                  st   <= rx_s ? S_IDLE : S_DATA;
               end else begin
                  tcnt <= tcnt + 4'd1;
               end
            end
            S_DATA: begin
               if (tcnt == 4'd15) begin
                  tcnt      <= '0;
                  data[idx] <= rx_s;
                  if (idx == last_idx) st <= fmt.par_en ? S_PAR : S_STOP;
                  else                 idx <= idx + 3'd1;
               end else begin
                  tcnt <= tcnt + 4'd1;
               end
            end
            S_PAR: begin
               if (tcnt == 4'd15) begin
                  tcnt <= '0;
                  pbit <= rx_s;
                  st   <= S_STOP;
               end else begin
                  tcnt <= tcnt + 4'd1;
               end
            end
            S_STOP: begin
               if (tcnt == 4'd15) begin
                  tcnt <= '0;
                  st   <= S_IDLE;
               end else begin
                  tcnt <= tcnt + 4'd1;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/apb_uart.sv
module apb_uart
   import uart_cfg_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int TICK_DIV   = 4,
   parameter bit USE_FIFO   = 1'b1,
   parameter int FIFO_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [7:0]        pwdata,
   output logic [7:0]        prdata,
   input  logic              rxd,
   output logic              txd,
   output logic              tx_ready,
   output logic              rx_ready,
   output logic              parity_err
);
   localparam logic [ADDR_W-1:0] A_TXD  = ADDR_W'(OFS_TXD);
   localparam logic [ADDR_W-1:0] A_RXD  = ADDR_W'(OFS_RXD);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

   if (ADDR_W < 4) begin : g_bad_addr
      $error("apb_uart: ADDR_W must cover offset 0x0C");
   end

   logic       access, wr_txd, wr_ctrl, rd_rxd;
   logic       tick16;
   frame_fmt_t fmt_q;
   logic       tx_empty, tx_full, tx_take;
   logic [7:0] tx_head;
   logic       rx_push, rx_empty, rx_full;
   logic [8:0] rx_word, rx_head;

   assign access  = psel && penable;
   assign wr_txd  = access && pwrite && (paddr == A_TXD);
   assign wr_ctrl = access && pwrite && (paddr == A_CTRL);
   assign rd_rxd  = access && !pwrite && (paddr == A_RXD);

   always_ff @(posedge clk) begin
      if (!rst_n)       fmt_q <= frame_fmt_t'(FMT_RESET);
      else if (wr_ctrl) fmt_q <= frame_fmt_t'(pwdata[2:0]);
   end

   uart_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick16)
   );

   uart_buf #(.W(8), .USE_FIFO(USE_FIFO), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(wr_txd), .din(pwdata),
      .pop(tx_take), .dout(tx_head),
      .empty(tx_empty), .full(tx_full)
   );

   uart_tx u_tx (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .fmt(fmt_q),
      .have_data(!tx_empty), .data(tx_head), .take(tx_take), .txd(txd)
   );

   uart_rx u_rx (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .fmt(fmt_q),
      .rxd(rxd), .push(rx_push), .word(rx_word)
   );

   uart_buf #(.W(9), .USE_FIFO(USE_FIFO), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .din(rx_word),
      .pop(rd_rxd), .dout(rx_head),
      .empty(rx_empty), .full(rx_full)
   );

   assign tx_ready   = !tx_full;
   assign rx_ready   = !rx_empty;
   assign parity_err = !rx_empty && rx_head[8];

   always_comb begin
      prdata = '0;
      if (paddr == A_RXD && !rx_empty) prdata = rx_head[7:0];
      else if (paddr == A_CTRL)        prdata = {5'b0, fmt_q};
   end
endmodule

// File: rtl/apb_uart_chk.sv
module apb_uart_chk #(
   parameter int ADDR_W   = 8,
   parameter bit USE_FIFO = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [7:0]        pwdata,
   input logic [2:0]        fmt,
   input logic              tick,
   input logic              txd,
   input logic              rx_ready,
   input logic              parity_err,
   input logic              rx_push
);
   // R6: the error flag only describes a waiting character
   p_perr_with_rdy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      parity_err |-> rx_ready);

   // R7: the serial line moves only on tick boundaries
   p_txd_on_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(txd) |-> $past(tick));

   // R2: a format write lands in the register on the next cycle
   p_fmt_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && penable && pwrite && paddr == ADDR_W'(12)) |=> fmt == $past(pwdata[2:0]));

   // R8: a character appears only when a frame completes
   p_rdy_from_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_ready) |-> $past(rx_push));

   if (!USE_FIFO) begin : g_hold_chk
      // R9: a read of the holding register empties it
      p_hold_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (psel && penable && !pwrite && paddr == ADDR_W'(4) && rx_ready && !rx_push)
         |=> !rx_ready);
   end
endmodule

bind apb_uart apb_uart_chk #(.ADDR_W(ADDR_W), .USE_FIFO(USE_FIFO)) u_chk (
   .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
   .paddr(paddr), .pwdata(pwdata), .fmt(fmt_q), .tick(tick16), .txd(txd),
   .rx_ready(rx_ready), .parity_err(parity_err), .rx_push(rx_push)
);

// File: tb/apb_uart_test.sv
`timescale 1ns/1ps
module apb_uart_test;
   localparam int TDIV  = 2;
   localparam int BITC  = 16 * TDIV;
   localparam int FRAME = 12 * BITC;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   // instance a (queued) and instance b (holding register)
   logic       a_psel = 0, a_pen = 0, a_pwr = 0;
   logic [7:0] a_addr = 0, a_wd = 0, a_rd;
   logic       a_txd, a_txr, a_rxr, a_perr;
   logic       b_psel = 0, b_pen = 0, b_pwr = 0;
   logic [7:0] b_addr = 0, b_wd = 0, b_rd;
   logic       b_txd, b_txr, b_rxr, b_perr;
   logic       glitch = 0;

   int n_checks = 0;
   int n_errors = 0;
   logic [8:0] expq[$];

   apb_uart #(.TICK_DIV(TDIV), .USE_FIFO(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .psel(a_psel), .penable(a_pen), .pwrite(a_pwr),
      .paddr(a_addr), .pwdata(a_wd), .prdata(a_rd), .rxd(b_txd), .txd(a_txd),
      .tx_ready(a_txr), .rx_ready(a_rxr), .parity_err(a_perr)
   );

   apb_uart #(.TICK_DIV(TDIV), .USE_FIFO(1'b0)) peer (
      .clk(clk), .rst_n(rst_n), .psel(b_psel), .penable(b_pen), .pwrite(b_pwr),
      .paddr(b_addr), .pwdata(b_wd), .prdata(b_rd), .rxd(a_txd & ~glitch), .txd(b_txd),
      .tx_ready(b_txr), .rx_ready(b_rxr), .parity_err(b_perr)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic a_write(input logic [7:0] ad, input logic [7:0] d);
      a_addr = ad; a_wd = d; a_pwr = 1; a_psel = 1; a_pen = 0;
      @(negedge clk); a_pen = 1;
      @(negedge clk); a_psel = 0; a_pen = 0;
   endtask

   task automatic a_read(input logic [7:0] ad, output logic [7:0] d);
      a_addr = ad; a_pwr = 0; a_psel = 1; a_pen = 0;
      @(negedge clk); a_pen = 1; #1 d = a_rd;
      @(negedge clk); a_psel = 0; a_pen = 0;
   endtask

   task automatic b_write(input logic [7:0] ad, input logic [7:0] d);
      b_addr = ad; b_wd = d; b_pwr = 1; b_psel = 1; b_pen = 0;
      @(negedge clk); b_pen = 1;
      @(negedge clk); b_psel = 0; b_pen = 0;
   endtask

   task automatic b_read(input logic [7:0] ad, output logic [7:0] d);
      b_addr = ad; b_pwr = 0; b_psel = 1; b_pen = 0;
      @(negedge clk); b_pen = 1; #1 d = b_rd;
      @(negedge clk); b_psel = 0; b_pen = 0;
   endtask

   // monitor side: take n characters from the peer and compare with the queue
   task automatic drain(input int n, input string req);
      logic [7:0] d;
      logic       pe;
      logic [8:0] e;
      for (int k = 0; k < n; k++) begin
         while (!b_rxr) @(negedge clk);
         pe = b_perr;
         b_read(8'h04, d);
         e = expq.pop_front();
         check({req, " data"}, d, e[7:0]);
         check({req, " parity flag"}, pe, e[8]);
      end
   endtask

   // driver: write when ready, push expectation; monitor runs alongside
   task automatic stream(input logic [7:0] fa, input logic [7:0] fb, input int n,
                         input logic [7:0] keep, input logic perr, input string req);
      a_write(8'h0C, fa);
      b_write(8'h0C, fb);
      repeat (10) @(negedge clk);
      fork
         begin
            for (int k = 0; k < n; k++) begin
               logic [7:0] d;
               d = 8'((k * 37 + 8'h91) & 8'hFF);
               while (!a_txr) @(negedge clk);
               expq.push_back({perr, d & keep});
               a_write(8'h00, d);
            end
         end
         drain(n, req);
      join
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic [9:0] bits;
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      check("R1 txd", a_txd, 1);
      check("R1 tx_ready", a_txr, 1);
      check("R1 rx_ready", a_rxr, 0);
      check("R1 parity_err", a_perr, 0);
      a_read(8'h0C, d);
      check("R1 format reset", d, 8'h05);

      // R2 format readback, upper bits dropped
      a_write(8'h0C, 8'hFE);
      a_read(8'h0C, d);
      check("R2 format readback", d, 8'h06);

      // R7 frame shape: 0xA5 with even parity -> bits 1,0,1,0,0,1,0,1, parity 0, stop 1
      a_write(8'h0C, 8'h03);
      b_write(8'h0C, 8'h03);
      repeat (10) @(negedge clk);
      a_write(8'h00, 8'hA5);
      while (a_txd) @(negedge clk);
      repeat (BITC / 2) @(negedge clk);
      check("R7 start bit", a_txd, 0);
      bits = 10'b1_0_10100101;
      for (int b = 0; b < 10; b++) begin
         repeat (BITC) @(negedge clk);
         check("R7 frame bit", a_txd, bits[b]);
      end
      while (!b_rxr) @(negedge clk);
      check("R7 parity flag", b_perr, 0);
      b_read(8'h04, d);
      check("R7 data", d, 8'hA5);

      stream(8'h05, 8'h05, 16, 8'hFF, 1'b0, "R3 8N1");
      stream(8'h04, 8'h04, 16, 8'h7F, 1'b0, "R4 7N1");
      stream(8'h03, 8'h03, 16, 8'hFF, 1'b0, "R5 even");
      stream(8'h07, 8'h07, 16, 8'hFF, 1'b0, "R5 odd");
      stream(8'h01, 8'h05, 16, 8'hFF, 1'b0, "R5 sense ignored");
      stream(8'h03, 8'h07, 16, 8'hFF, 1'b1, "R6 even to odd");
      stream(8'h07, 8'h03, 16, 8'hFF, 1'b1, "R6 odd to even");

      // R11 burst into the queue: 17 taken (one on line + 16 waiting), 18th dropped
      a_write(8'h0C, 8'h05);
      b_write(8'h0C, 8'h05);
      repeat (10) @(negedge clk);
      fork
         begin
            for (int k = 0; k < 17; k++) begin
               expq.push_back({1'b0, 8'(k + 8'h40)});
               a_write(8'h00, 8'(k + 8'h40));
            end
            check("R11 tx_ready when full", a_txr, 0);
            a_write(8'h00, 8'hEE);
         end
         drain(17, "R11 burst");
      join
      repeat (2 * FRAME) @(negedge clk);
      check("R11 dropped write", b_rxr, 0);

      // R8 glitch shorter than half a bit
      glitch = 1;
      repeat (BITC / 4) @(negedge clk);
      glitch = 0;
      repeat (2 * FRAME) @(negedge clk);
      check("R8 glitch rejected", b_rxr, 0);
      a_write(8'h00, 8'h3C);
      while (!b_rxr) @(negedge clk);
      b_read(8'h04, d);
      check("R8 receive after glitch", d, 8'h3C);

      // R9 queued characters with different parity status
      a_write(8'h0C, 8'h03);
      b_write(8'h0C, 8'h07);
      repeat (10) @(negedge clk);
      b_write(8'h00, 8'h3C);
      repeat (2 * FRAME) @(negedge clk);
      b_write(8'h0C, 8'h03);
      b_write(8'h00, 8'h5A);
      repeat (2 * FRAME) @(negedge clk);
      check("R9 first ready", a_rxr, 1);
      check("R9 first flagged", a_perr, 1);
      a_read(8'h04, d);
      check("R9 first data", d, 8'h3C);
      check("R9 next ready", a_rxr, 1);
      check("R9 next not flagged", a_perr, 0);
      a_read(8'h04, d);
      check("R9 next data", d, 8'h5A);
      check("R9 empty after reads", a_rxr, 0);

      // R10 holding register: one waits while one is on the line, third dropped
      a_write(8'h0C, 8'h05);
      b_write(8'h0C, 8'h05);
      repeat (10) @(negedge clk);
      b_write(8'h00, 8'h11);
      repeat (6) @(negedge clk);
      check("R10 holding freed", b_txr, 1);
      b_write(8'h00, 8'h22);
      check("R10 holding full", b_txr, 0);
      b_write(8'h00, 8'h33);
      repeat (3 * FRAME) @(negedge clk);
      a_read(8'h04, d);
      check("R10 first", d, 8'h11);
      a_read(8'h04, d);
      check("R10 second", d, 8'h22);
      check("R10 third discarded", a_rxr, 0);

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule